// File: doc/BRIEF.md
# Selectable-Polynomial Transparent CRC Unit

This block adds and checks a frame check sequence on a bit-serial transparent channel. One serial CRC engine serves three polynomials, chosen at run time by a two-bit select. The transmit side accepts octets with a frame-end marker and a per-frame append flag. It serialises each octet onto a one-bit line stream and updates the CRC with every line bit. When the frame ends with the append flag set, it shifts the check field out behind the data. The receive side takes line bits with a frame-end marker. It runs the same engine over data and check field together, and at frame end it reports pass or fail by comparing the residue with a fixed good value.

A reverse-data option sets the octet bit order on the line. The polynomial select and the bit order are captured at the start of each frame, so a change made in the middle of a frame only takes effect on the next frame. A reserved select code turns checking off and raises a configuration-error flag.

Both transmit streams use valid/ready. An octet is accepted when `tx_in_valid` and `tx_in_ready` are both high at a clock edge. A line bit leaves when `tx_out_valid` and `tx_out_ready` are both high. While `tx_out_ready` is low, the offered bit and its frame-end marker stay unchanged. The receive input has no ready: a line cannot be paused, so every cycle with `rx_valid` high delivers one bit.

Top module: `tcrc_unit`

## Requirements
- R1: Select 2'b00 uses x^16+x^12+x^5+1 with the register preset to 16'hFFFF. A frame with a check carries 16 check bits, inverted.
- R2: Select 2'b01 uses x^16+x^15+x^2+1 with the register preset to zero. A frame with a check carries 16 check bits, not inverted.
- R3: Select 2'b10 uses the 32-bit polynomial 32'h04C11DB7 (x^32 implied) with the register preset to all ones. A frame with a check carries 32 check bits, inverted.
- R4: Select 2'b11 is reserved. Under it no check field is sent, even when append is requested, and the receiver never reports an error. `cfg_err` is high in the cycle after a clock edge at which `crc_sel` was 2'b11, and low otherwise.
- R5: Whether a check field follows is taken from `tx_in_append` of the frame's last octet. With it low, `tx_out_last` marks the final data bit and no check bits follow.
- R6: `rx_done` pulses in the cycle after the bit marked `rx_last` is taken. `rx_crc_err` is then high exactly when the residue differs from 16'h1D0F (select 00), 16'h0000 (select 01) or 32'hC704DD7B (select 10).
- R7: With `rev_data` low, each octet goes onto the line bit 0 first. With it high, bit 7 goes first. In both cases the check field is sent highest-order coefficient first, and the CRC covers the bits in line order.
- R8: `crc_sel` and `rev_data` are captured with a frame's first octet (transmit) or first bit (receive). Changes during the frame have no effect on that frame.
- R9: While `tx_out_valid` is high and `tx_out_ready` is low, `tx_out_valid`, `tx_out_bit` and `tx_out_last` hold their values into the next cycle.
- R10: The transmitter holds one octet at a time. `tx_in_ready` drops in the cycle after an accept and returns once that octet's last line bit (or the check field's last bit) has been taken.
- R11: After reset `tx_in_ready` is 1 and `tx_out_valid`, `rx_done` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_sel | input | 2 | Polynomial select, captured at frame start |
| rev_data | input | 1 | 1 = octet sent MSB first, captured at frame start |
| cfg_err | output | 1 | Reserved select code seen |
| tx_in_valid | input | 1 | Octet offered |
| tx_in_ready | output | 1 | Octet can be taken |
| tx_in_data | input | 8 | Octet value |
| tx_in_last | input | 1 | Octet closes the frame |
| tx_in_append | input | 1 | Send check field after this frame (read on last octet) |
| tx_out_valid | output | 1 | Line bit offered |
| tx_out_ready | input | 1 | Line bit taken |
| tx_out_bit | output | 1 | Line bit value |
| tx_out_last | output | 1 | Bit closes the frame |
| rx_valid | input | 1 | Received line bit present |
| rx_bit | input | 1 | Received line bit value |
| rx_last | input | 1 | Bit closes the received frame |
| rx_done | output | 1 | Verdict pulse |
| rx_crc_err | output | 1 | Residue mismatch, valid with rx_done |

## Verification
Frames are built from random octets of one to five bytes. The bench varies the select code, bit order, append flag and stall pattern on the line output, and compares the transmitted line bits with a bench-side serial model. That comparison tells the three polynomials, presets and inversions apart. It also shows whether the check field is present and whether each octet goes out LSB or MSB first. The captured line stream is then sent back into the receiver both intact and with one bit flipped. This separates a correct residue compare from one that always passes or always fails. Directed frames change the select mid-frame on both paths, use the reserved code with append requested, and check that no check field and no error result.

// File: rtl/tcrc_pkg.sv
package tcrc_pkg;

  localparam int CRC_MAXW = 32;

  typedef enum logic [1:0] {
    SEL_CCITT = 2'b00,
    SEL_CRC16 = 2'b01,
    SEL_CRC32 = 2'b10,
    SEL_RSVD  = 2'b11
  } crc_sel_e;

  function automatic logic [CRC_MAXW-1:0] poly_of(input logic [1:0] s);
    case (s)
      SEL_CCITT: poly_of = 32'h0000_1021;
      SEL_CRC16: poly_of = 32'h0000_8005;
      SEL_CRC32: poly_of = 32'h04C1_1DB7;
      default:   poly_of = '0;
    endcase
  endfunction

  function automatic logic [CRC_MAXW-1:0] init_of(input logic [1:0] s);
    case (s)
      SEL_CCITT: init_of = 32'h0000_FFFF;
      SEL_CRC32: init_of = 32'hFFFF_FFFF;
      default:   init_of = '0;
    endcase
  endfunction

  function automatic logic [CRC_MAXW-1:0] good_of(input logic [1:0] s);
    case (s)
      SEL_CCITT: good_of = 32'h0000_1D0F;
      SEL_CRC32: good_of = 32'hC704_DD7B;
      default:   good_of = '0;
    endcase
  endfunction

  // index of the highest-order register bit for the selected width
  function automatic logic [4:0] top_of(input logic [1:0] s);
    top_of = (s == SEL_CRC32) ? 5'd31 : 5'd15;
  endfunction

  function automatic logic inv_of(input logic [1:0] s);
    inv_of = (s == SEL_CCITT) || (s == SEL_CRC32);
  endfunction

endpackage

// File: rtl/tcrc_step.sv
module tcrc_step
  import tcrc_pkg::*;
(
  input  logic [CRC_MAXW-1:0] cur,
  input  logic                din,
  input  logic [1:0]          sel,
  output logic [CRC_MAXW-1:0] nxt
);

  logic [4:0]          top;
  logic                fb;
  logic [CRC_MAXW-1:0] mask;

  always_comb begin
    top  = top_of(sel);
    fb   = cur[top] ^ din;
    mask = (sel == SEL_CRC32) ? {CRC_MAXW{1'b1}} : 32'h0000_FFFF;
    nxt  = ((cur << 1) ^ (fb ? poly_of(sel) : '0)) & mask;
  end

endmodule

// File: rtl/tcrc_tx.sv
module tcrc_tx
  import tcrc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        crc_sel,
  input  logic              rev_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_append,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic              out_last
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_FCS} tx_st_e;

  tx_st_e              st;
  logic [DATA_W-1:0]   shreg;
  logic [CNT_W-1:0]    bitcnt;
  logic [4:0]          fcscnt;
  logic [CRC_MAXW-1:0] crc;
  logic [CRC_MAXW-1:0] crc_nxt;
  logic                in_frame;
  logic [1:0]          frame_sel;
  logic                frame_rev;
  logic                hold_last;
  logic                hold_app;

  logic       data_bit;
  logic       fcs_bit;
  logic       fcs_go;
  logic       byte_end;
  logic [4:0] top;

  assign top      = top_of(frame_sel);
  assign data_bit = frame_rev ? shreg[DATA_W-1] : shreg[0];
  assign fcs_bit  = crc[top] ^ inv_of(frame_sel);
  assign fcs_go   = hold_app && (frame_sel != SEL_RSVD);
  assign byte_end = (bitcnt == CNT_END);

  assign in_ready  = (st == TX_IDLE);
  assign out_valid = (st != TX_IDLE);
  assign out_bit   = (st == TX_FCS) ? fcs_bit : data_bit;
  assign out_last  = ((st == TX_DATA) && byte_end && hold_last && !fcs_go) ||
                     ((st == TX_FCS) && (fcscnt == top));

  tcrc_step u_step (
    .cur (crc),
    .din (data_bit),
    .sel (frame_sel),
    .nxt (crc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      fcscnt    <= '0;
      crc       <= '0;
      in_frame  <= 1'b0;
      frame_sel <= 2'b00;
      frame_rev <= 1'b0;
      hold_last <= 1'b0;
      hold_app  <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (in_valid) begin
            st        <= TX_DATA;
            shreg     <= in_data;
            bitcnt    <= '0;
            hold_last <= in_last;
            hold_app  <= in_append;
            if (!in_frame) begin
              in_frame  <= 1'b1;
              frame_sel <= crc_sel;
              frame_rev <= rev_data;
              crc       <= init_of(crc_sel);
            end
          end
        end
        TX_DATA: begin
          if (out_ready) begin
            crc    <= crc_nxt;
            shreg  <= frame_rev ? {shreg[DATA_W-2:0], 1'b0} : {1'b0, shreg[DATA_W-1:1]};
            bitcnt <= bitcnt + 1'b1;
            if (byte_end) begin
              if (hold_last && fcs_go) begin
                st     <= TX_FCS;
                fcscnt <= '0;
              end else begin
                st <= TX_IDLE;
                if (hold_last) in_frame <= 1'b0;
              end
            end
          end
        end
        TX_FCS: begin
          if (out_ready) begin
            crc    <= crc << 1;
            fcscnt <= fcscnt + 5'd1;
            if (fcscnt == top) begin
              st       <= TX_IDLE;
              in_frame <= 1'b0;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit) && $stable(out_last));

  a_r10_single_octet: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  a_r4_no_fcs_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_FCS) |-> (frame_sel != SEL_RSVD));

  a_r5_end_frees_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready);

endmodule

// File: rtl/tcrc_rx.sv
module tcrc_rx
  import tcrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] crc_sel,
  input  logic       rx_valid,
  input  logic       rx_bit,
  input  logic       rx_last,
  output logic       rx_done,
  output logic       rx_crc_err
);

  logic                in_frame;
  logic [1:0]          frame_sel;
  logic [CRC_MAXW-1:0] crc;
  logic [1:0]          cur_sel;
  logic [CRC_MAXW-1:0] cur_crc;
  logic [CRC_MAXW-1:0] crc_nxt;

  assign cur_sel = in_frame ? frame_sel : crc_sel;
  assign cur_crc = in_frame ? crc : init_of(crc_sel);

  tcrc_step u_step (
    .cur (cur_crc),
    .din (rx_bit),
    .sel (cur_sel),
    .nxt (crc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      frame_sel  <= 2'b00;
      crc        <= '0;
      rx_done    <= 1'b0;
      rx_crc_err <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (rx_valid) begin
        if (rx_last) begin
          in_frame   <= 1'b0;
          rx_done    <= 1'b1;
          rx_crc_err <= (cur_sel != SEL_RSVD) && (crc_nxt != good_of(cur_sel));
        end else begin
          in_frame  <= 1'b1;
          frame_sel <= cur_sel;
          crc       <= crc_nxt;
        end
      end
    end
  end

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(rx_valid && rx_last));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_last) |=> !rx_done);

endmodule

// File: rtl/tcrc_unit.sv
module tcrc_unit
  import tcrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] crc_sel,
  input  logic       rev_data,
  output logic       cfg_err,
  input  logic       tx_in_valid,
  output logic       tx_in_ready,
  input  logic [7:0] tx_in_data,
  input  logic       tx_in_last,
  input  logic       tx_in_append,
  output logic       tx_out_valid,
  input  logic       tx_out_ready,
  output logic       tx_out_bit,
  output logic       tx_out_last,
  input  logic       rx_valid,
  input  logic       rx_bit,
  input  logic       rx_last,
  output logic       rx_done,
  output logic       rx_crc_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= (crc_sel == SEL_RSVD);
  end

  tcrc_tx #(.DATA_W(8)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_sel   (crc_sel),
    .rev_data  (rev_data),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_in_data),
    .in_last   (tx_in_last),
    .in_append (tx_in_append),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_bit   (tx_out_bit),
    .out_last  (tx_out_last)
  );

  tcrc_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .crc_sel    (crc_sel),
    .rx_valid   (rx_valid),
    .rx_bit     (rx_bit),
    .rx_last    (rx_last),
    .rx_done    (rx_done),
    .rx_crc_err (rx_crc_err)
  );

  a_r4_cfg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($past(crc_sel) == 2'b11));

endmodule

// File: tb/tcrc_unit_bench.sv
module tcrc_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] crc_sel = 2'b00;
  logic       rev_data = 1'b0;
  logic       cfg_err;
  logic       tx_in_valid = 1'b0;
  logic       tx_in_ready;
  logic [7:0] tx_in_data = 8'h00;
  logic       tx_in_last = 1'b0;
  logic       tx_in_append = 1'b0;
  logic       tx_out_valid;
  logic       tx_out_ready = 1'b0;
  logic       tx_out_bit;
  logic       tx_out_last;
  logic       rx_valid = 1'b0;
  logic       rx_bit = 1'b0;
  logic       rx_last = 1'b0;
  logic       rx_done;
  logic       rx_crc_err;

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0] bytes_q[$];
  bit         line_q[$];
  bit         exp_q[$];
  bit         got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tcrc_unit u_tcrc_unit (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string sel_tag(input int sel);
    case (sel)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // serial model over line_q[0 .. n-1]
  function automatic logic [31:0] mdl_crc(input int sel, input int n);
    logic [31:0] s, p, m;
    int w;
    bit fb;
    case (sel)
      0: begin s = 32'hFFFF;      p = 32'h1021;      w = 16; end
      1: begin s = 32'h0;         p = 32'h8005;      w = 16; end
      default: begin s = 32'hFFFFFFFF; p = 32'h04C11DB7; w = 32; end
    endcase
    m = (w == 32) ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int i = 0; i < n; i++) begin
      fb = s[w-1] ^ line_q[i];
      s  = ((s << 1) ^ (fb ? p : 32'h0)) & m;
    end
    return s;
  endfunction

  function automatic logic [31:0] good_val(input int sel);
    case (sel)
      0: return 32'h1D0F;
      1: return 32'h0;
      default: return 32'hC704DD7B;
    endcase
  endfunction

  task automatic build_expected(input int sel, input bit rev, input bit app);
    logic [31:0] s;
    int w;
    bit inv;
    line_q.delete();
    foreach (bytes_q[k])
      for (int i = 0; i < 8; i++)
        line_q.push_back(rev ? bytes_q[k][7-i] : bytes_q[k][i]);
    if (app && sel != 3) begin
      s   = mdl_crc(sel, line_q.size());
      w   = (sel == 2) ? 32 : 16;
      inv = (sel != 1);
      for (int i = 0; i < w; i++) line_q.push_back(s[w-1-i] ^ inv);
    end
    exp_q = line_q;
  endtask

  task automatic drive_tx(input bit app, input bit mid, input int mid_sel, input bit rev);
    for (int i = 0; i < bytes_q.size(); i++) begin
      repeat ($urandom % 3) @(negedge clk);
      @(negedge clk);
      tx_in_valid  = 1'b1;
      tx_in_data   = bytes_q[i];
      tx_in_last   = (i == bytes_q.size() - 1);
      tx_in_append = app;
      while (!tx_in_ready) @(negedge clk);
      @(negedge clk);
      tx_in_valid = 1'b0;
      check(tx_in_ready == 1'b0, "R10", "ready after accept", 64'(tx_in_ready), 64'd0);
      if (i == 0 && mid) begin
        crc_sel  = 2'(mid_sel);
        rev_data = ~rev;
      end
    end
  endtask

  task automatic collect_tx();
    bit r, fin, stall, pbit, plast;
    got_q.delete();
    fin = 0; stall = 0; pbit = 0; plast = 0;
    while (!fin) begin
      @(negedge clk);
      if (stall)
        check(tx_out_valid && tx_out_bit == pbit && tx_out_last == plast, "R9",
              "output held under stall", {61'd0, tx_out_valid, tx_out_bit, tx_out_last},
              {61'd0, 1'b1, pbit, plast});
      r = ($urandom % 4) != 0;
      tx_out_ready = r;
      if (tx_out_valid && r) begin
        got_q.push_back(tx_out_bit);
        if (tx_out_last) fin = 1;
      end
      stall = tx_out_valid && !r;
      pbit  = tx_out_bit;
      plast = tx_out_last;
    end
    @(negedge clk);
    tx_out_ready = 1'b0;
  endtask

  // feeds got_q into the receiver, optionally flipping one bit
  task automatic feed_rx(input int sel, input bit corrupt, input bit mid, input string tag);
    bit exp_err;
    int flip;
    line_q = got_q;
    if (corrupt && line_q.size() > 0) begin
      flip = $urandom % line_q.size();
      line_q[flip] = ~line_q[flip];
    end
    exp_err = (sel != 3) && (mdl_crc(sel, line_q.size()) != good_val(sel));
    crc_sel = 2'(sel);
    for (int i = 0; i < line_q.size(); i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_bit   = line_q[i];
      rx_last  = (i == line_q.size() - 1);
      if (i == 1 && mid) crc_sel = 2'(sel ^ 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    check(rx_done == 1'b1, "R6", "rx_done after last bit", 64'(rx_done), 64'd1);
    check(rx_crc_err == exp_err, tag, "rx verdict", 64'(rx_crc_err), 64'(exp_err));
    @(negedge clk);
    check(rx_done == 1'b0, "R6", "rx_done single pulse", 64'(rx_done), 64'd0);
  endtask

  task automatic run_frame(input int sel, input bit rev, input bit app, input int n,
                           input bit corrupt, input bit mid, input int mid_sel);
    bit same;
    bytes_q.delete();
    for (int i = 0; i < n; i++) bytes_q.push_back(8'($urandom));
    @(negedge clk);
    crc_sel  = 2'(sel);
    rev_data = rev;
    build_expected(sel, rev, app);
    fork
      drive_tx(app, mid, mid_sel, rev);
      collect_tx();
    join
    same = (got_q.size() == exp_q.size());
    if (same) foreach (exp_q[i]) if (got_q[i] != exp_q[i]) same = 0;
    check(same, sel_tag(sel), "tx line sequence", 64'(got_q.size()), 64'(exp_q.size()));
    if (mid) check(same, "R8", "tx mid-frame select change ignored", 64'(got_q.size()), 64'(exp_q.size()));
    if (!app || sel == 3)
      check(got_q.size() == n * 8, "R5", "no check field", 64'(got_q.size()), 64'(n * 8));
    if (rev && got_q.size() > 0)
      check(got_q[0] == bytes_q[0][7], "R7", "msb first", 64'(got_q[0]), 64'(bytes_q[0][7]));
    if (!rev && got_q.size() > 0)
      check(got_q[0] == bytes_q[0][0], "R7", "lsb first", 64'(got_q[0]), 64'(bytes_q[0][0]));
    feed_rx(sel, corrupt, 1'b0, (sel == 3) ? "R4" : "R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_in_ready == 1'b1, "R11", "reset ready", 64'(tx_in_ready), 64'd1);
    check(tx_out_valid == 1'b0, "R11", "reset out_valid", 64'(tx_out_valid), 64'd0);
    check(rx_done == 1'b0, "R11", "reset rx_done", 64'(rx_done), 64'd0);
    check(cfg_err == 1'b0, "R11", "reset cfg_err", 64'(cfg_err), 64'd0);

    // reserved code flag
    crc_sel = 2'b11;
    @(negedge clk);
    check(cfg_err == 1'b1, "R4", "cfg_err on reserved", 64'(cfg_err), 64'd1);
    crc_sel = 2'b00;
    @(negedge clk);
    check(cfg_err == 1'b0, "R4", "cfg_err cleared", 64'(cfg_err), 64'd0);

    // directed corners
    run_frame(0, 0, 1, 2, 0, 0, 0);
    run_frame(1, 0, 1, 3, 0, 0, 0);
    run_frame(2, 0, 1, 4, 0, 0, 0);
    run_frame(0, 1, 1, 1, 1, 0, 0);
    run_frame(2, 1, 0, 2, 0, 0, 0);
    run_frame(3, 0, 1, 2, 1, 0, 0);
    run_frame(0, 0, 1, 3, 0, 1, 2);
    run_frame(2, 1, 1, 2, 0, 1, 1);

    // receiver select change after first bit
    bytes_q.delete();
    bytes_q.push_back(8'hA5);
    bytes_q.push_back(8'h3C);
    build_expected(2, 0, 1);
    got_q = exp_q;
    line_q = got_q;
    check(mdl_crc(2, line_q.size()) == 32'hC704DD7B, "R3", "bench model residue",
          64'(mdl_crc(2, line_q.size())), 64'hC704DD7B);
    feed_rx(2, 0, 1, "R8");
    crc_sel = 2'b00;

    // random frames
    for (int f = 0; f < 40; f++)
      run_frame($urandom % 4, 1'($urandom), 1'($urandom % 3 != 0), 1 + $urandom % 5,
                1'($urandom % 3 == 0), 1'($urandom % 5 == 0), $urandom % 3);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule